// File: doc/BRIEF.md
# Conditional Branch and Stack Sequencer

This block carries out the flow-change instructions of an 8-bit processor that uses 16-bit addresses. It holds the program counter and the stack pointer. The opcode byte has already been fetched, so when an instruction is started the program counter points at the byte after the opcode. The sequencer then fetches any two-byte target address, tests one of eight flag conditions, pushes or pops return addresses through a byte-wide memory port, and writes the new program counter. The four flags are sampled in the cycle the instruction is accepted.

Each instruction keeps the block busy for exactly its architectural cycle cost. That cost is shown on `cycleCost` in the final busy cycle, which is marked by a one-cycle `done`, so cycle accounting can be checked from outside. The memory port gives its read data combinationally in the same cycle as the request. A write is taken at the clock edge that ends the request cycle.

Top module: `branch_stack_seq`

## Requirements
- R1: After reset, `pc` equals PC_RESET (default 0x0000), `sp` equals SP_RESET (default 0xFF00), and `busy`, `done` and `memReq` are low.
- R2: Conditional forms carry a condition code in opcode bits 5:3. The codes are 0 zero clear, 1 zero set, 2 carry clear, 3 carry set, 4 parity clear, 5 parity set, 6 sign clear and 7 sign set. The flags are taken from the inputs in the cycle of acceptance.
- R3: Jump is 0xC3 (unconditional) or 11ccc010 (conditional). It reads the low target byte at `pc` and then the high byte at `pc`+1, which leaves `pc` advanced by 2. A taken jump then loads the target. Cost: 10 cycles if taken or unconditional, 7 if not taken.
- R4: Call is 0xCD (unconditional) or 11ccc100 (conditional). It reads the target as in R3. When taken, it writes the return address (`pc`+2) high byte at `sp`-1 and then low byte at `sp`-2, lowers `sp` by 2, and loads the target, for a cost of 18 cycles. When not taken it costs 9 cycles, makes no write, leaves `sp` alone, and ends with `pc` advanced by 2.
- R5: Return is 0xC9 (unconditional) or 11ccc000 (conditional). When taken it reads the low byte at `sp` and then the high byte at `sp`+1, raises `sp` by 2, and loads `pc` from the two bytes. Cost: 10 cycles unconditional, 12 taken, and 6 not taken with no memory access.
- R6: Restart is 11nnn111. It pushes the current `pc` (high byte at `sp`-1, low byte at `sp`-2), lowers `sp` by 2, and loads `pc` with 8*n, for a cost of 12 cycles.
- R7: Opcode 0xE9 loads `pc` from `hl` in 6 cycles, with no memory access and no change to `sp`.
- R8: From acceptance, `busy` stays high for exactly the instruction's cost. `done` is high only in the last busy cycle, and in that cycle `cycleCost` equals the cost.
- R9: A start while `busy` is high is ignored, and so is a start with any opcode not listed in R3 to R7. In both cases `pc` and `sp` stay unchanged.
- R10: Memory requests occur only while busy, at most one byte per cycle. The number of accesses is 2 for a jump, a not-taken call, a taken return and a restart, 4 for a taken call, and 0 otherwise. Writes occur only for pushes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| startValid | input | 1 | Request to begin the instruction on `opcode` |
| opcode | input | 8 | Flow-change opcode |
| flagZero | input | 1 | Zero flag |
| flagCarry | input | 1 | Carry flag |
| flagParity | input | 1 | Parity flag (1 = even) |
| flagSign | input | 1 | Sign flag |
| hl | input | 16 | Register pair used as the target by 0xE9 |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | Last cycle of the instruction |
| cycleCost | output | 5 | Cycle cost of the current instruction |
| pc | output | 16 | Program counter |
| sp | output | 16 | Stack pointer |
| memReq | output | 1 | Memory access this cycle |
| memWe | output | 1 | The access is a write |
| memAddr | output | 16 | Byte address |
| memWdata | output | 8 | Write data |
| memRdata | input | 8 | Read data, valid in the request cycle |

## Verification
Two functions can meet in one cycle: a new start request and the last cycle of the running instruction, where `done` is high and the program counter is loaded. The bench holds `startValid` high with a valid opcode for the whole length of a jump, including its `done` cycle, and then drops it. The run passes if the jump finishes with the expected target and cost and the sequencer is idle afterwards with `pc` unchanged. It fails if the held request was taken up at any point. The bench also starts each instruction on the cycle right after the previous one finishes, so a start always closely follows a program-counter load.

// File: rtl/branch_stack_pkg.sv
package branch_stack_pkg;

  localparam int OPC_W = 8;
  localparam int CNT_W = 5;

  localparam logic [OPC_W-1:0] OPC_JUMP  = 8'hC3;
  localparam logic [OPC_W-1:0] OPC_CALL  = 8'hCD;
  localparam logic [OPC_W-1:0] OPC_RET   = 8'hC9;
  localparam logic [OPC_W-1:0] OPC_HLJMP = 8'hE9;

  localparam logic [CNT_W-1:0] COST_JUMP_TAKEN = 5'd10;
  localparam logic [CNT_W-1:0] COST_JUMP_SKIP  = 5'd7;
  localparam logic [CNT_W-1:0] COST_CALL_TAKEN = 5'd18;
  localparam logic [CNT_W-1:0] COST_CALL_SKIP  = 5'd9;
  localparam logic [CNT_W-1:0] COST_RET_UNCOND = 5'd10;
  localparam logic [CNT_W-1:0] COST_RET_TAKEN  = 5'd12;
  localparam logic [CNT_W-1:0] COST_RET_SKIP   = 5'd6;
  localparam logic [CNT_W-1:0] COST_RESTART    = 5'd12;
  localparam logic [CNT_W-1:0] COST_HLJMP      = 5'd6;

  typedef enum logic [2:0] {
    KIND_NONE, KIND_JUMP, KIND_CALL, KIND_RET, KIND_RESTART, KIND_HLJMP
  } opKind_t;

  // Strobes from control to datapath, one per datapath action
  typedef struct packed {
    logic capHl;    // latch hl as the pending target
    logic capVec;   // latch the restart vector as the pending target
    logic rdLo;     // fetch target low byte at pc, pc+1
    logic rdHi;     // fetch target high byte at pc, pc+1
    logic pushHi;   // write pc high byte at sp-1, sp-1
    logic pushLo;   // write pc low byte at sp-1, sp-1
    logic popLo;    // read low byte at sp, sp+1
    logic popHi;    // read high byte at sp, sp+1
    logic loadPc;   // pc <= pending target
  } seqStrobe_t;

  // Condition code evaluation: bit 0 selects the "set" sense
  function automatic logic condMet(input logic [2:0] code, input logic fz,
                                   input logic fc, input logic fp, input logic fs);
    logic sel;
    case (code[2:1])
      2'd0:    sel = fz;
      2'd1:    sel = fc;
      2'd2:    sel = fp;
      default: sel = fs;
    endcase
    return code[0] ? sel : ~sel;
  endfunction

endpackage

// File: rtl/branch_stack_ctrl.sv
module branch_stack_ctrl
  import branch_stack_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             startValid,
  input  logic [OPC_W-1:0] opcode,
  input  logic             flagZero,
  input  logic             flagCarry,
  input  logic             flagParity,
  input  logic             flagSign,
  output seqStrobe_t       strobe,
  output logic             busy,
  output logic             done,
  output logic [CNT_W-1:0] cycleCost
);

  opKind_t          kindD, kindQ;
  logic             uncondD, takenD, takenQ, accept, lastCyc;
  logic [CNT_W-1:0] costD, costQ, cyc;

  // Opcode decode
  always_comb begin
    kindD   = KIND_NONE;
    uncondD = 1'b0;
    if (opcode == OPC_JUMP) begin
      kindD = KIND_JUMP; uncondD = 1'b1;
    end else if (opcode == OPC_CALL) begin
      kindD = KIND_CALL; uncondD = 1'b1;
    end else if (opcode == OPC_RET) begin
      kindD = KIND_RET; uncondD = 1'b1;
    end else if (opcode == OPC_HLJMP) begin
      kindD = KIND_HLJMP; uncondD = 1'b1;
    end else if (opcode[7:6] == 2'b11) begin
      case (opcode[2:0])
        3'b010:  kindD = KIND_JUMP;
        3'b100:  kindD = KIND_CALL;
        3'b000:  kindD = KIND_RET;
        3'b111:  begin kindD = KIND_RESTART; uncondD = 1'b1; end
        default: kindD = KIND_NONE;
      endcase
    end
  end

  assign takenD = uncondD | condMet(opcode[5:3], flagZero, flagCarry, flagParity, flagSign);

  always_comb begin
    case (kindD)
      KIND_JUMP:    costD = takenD ? COST_JUMP_TAKEN : COST_JUMP_SKIP;
      KIND_CALL:    costD = takenD ? COST_CALL_TAKEN : COST_CALL_SKIP;
      KIND_RET:     costD = uncondD ? COST_RET_UNCOND
                                    : (takenD ? COST_RET_TAKEN : COST_RET_SKIP);
      KIND_RESTART: costD = COST_RESTART;
      KIND_HLJMP:   costD = COST_HLJMP;
      default:      costD = '0;
    endcase
  end

  assign accept  = startValid && !busy && (kindD != KIND_NONE);
  assign lastCyc = busy && (cyc == costQ - 1'b1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy   <= 1'b0;
      cyc    <= '0;
      costQ  <= '0;
      kindQ  <= KIND_NONE;
      takenQ <= 1'b0;
    end else if (accept) begin
      busy   <= 1'b1;
      cyc    <= '0;
      costQ  <= costD;
      kindQ  <= kindD;
      takenQ <= takenD;
    end else if (busy) begin
      if (lastCyc) busy <= 1'b0;
      else         cyc  <= cyc + 1'b1;
    end
  end

  // Fixed slot schedule inside the cost window
  always_comb begin
    strobe        = '0;
    strobe.capHl  = accept && (kindD == KIND_HLJMP);
    strobe.capVec = accept && (kindD == KIND_RESTART);
    if (busy) begin
      case (kindQ)
        KIND_JUMP: begin
          strobe.rdLo   = (cyc == 5'd0);
          strobe.rdHi   = (cyc == 5'd1);
          strobe.loadPc = lastCyc && takenQ;
        end
        KIND_CALL: begin
          strobe.rdLo   = (cyc == 5'd0);
          strobe.rdHi   = (cyc == 5'd1);
          strobe.pushHi = (cyc == 5'd2) && takenQ;
          strobe.pushLo = (cyc == 5'd3) && takenQ;
          strobe.loadPc = lastCyc && takenQ;
        end
        KIND_RET: begin
          strobe.popLo  = (cyc == 5'd0) && takenQ;
          strobe.popHi  = (cyc == 5'd1) && takenQ;
          strobe.loadPc = lastCyc && takenQ;
        end
        KIND_RESTART: begin
          strobe.pushHi = (cyc == 5'd0);
          strobe.pushLo = (cyc == 5'd1);
          strobe.loadPc = lastCyc;
        end
        KIND_HLJMP: strobe.loadPc = lastCyc;
        default: ;
      endcase
    end
  end

  assign done      = lastCyc;
  assign cycleCost = costQ;

endmodule

// File: rtl/branch_stack_dp.sv
module branch_stack_dp
  import branch_stack_pkg::*;
#(
  parameter int          DATA_W   = 8,
  parameter int unsigned PC_RESET = 0,
  parameter int unsigned SP_RESET = 'hFF00,
  localparam int         ADDR_W   = 2 * DATA_W
)(
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strobe,
  input  logic [2:0]        vecSel,
  input  logic [ADDR_W-1:0] hl,
  input  logic [DATA_W-1:0] memRdata,
  output logic [ADDR_W-1:0] pc,
  output logic [ADDR_W-1:0] sp,
  output logic              memReq,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata
);

  logic [ADDR_W-1:0] target;
  logic              isRd, isPop, isPush;

  assign isRd   = strobe.rdLo  | strobe.rdHi;
  assign isPop  = strobe.popLo | strobe.popHi;
  assign isPush = strobe.pushHi | strobe.pushLo;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pc     <= ADDR_W'(PC_RESET);
      sp     <= ADDR_W'(SP_RESET);
      target <= '0;
    end else begin
      if (strobe.capHl)  target <= hl;
      if (strobe.capVec) target <= {{(ADDR_W-6){1'b0}}, vecSel, 3'b000};
      if (strobe.rdLo | strobe.popLo) target[DATA_W-1:0]      <= memRdata;
      if (strobe.rdHi | strobe.popHi) target[ADDR_W-1:DATA_W] <= memRdata;
      if (isRd)   pc <= pc + 1'b1;
      if (isPop)  sp <= sp + 1'b1;
      if (isPush) sp <= sp - 1'b1;
      if (strobe.loadPc) pc <= target;
    end
  end

  assign memReq   = isRd | isPop | isPush;
  assign memWe    = isPush;
  assign memAddr  = isRd ? pc : (isPop ? sp : sp - 1'b1);
  assign memWdata = strobe.pushHi ? pc[ADDR_W-1:DATA_W] : pc[DATA_W-1:0];

endmodule

// File: rtl/branch_stack_seq.sv
module branch_stack_seq
  import branch_stack_pkg::*;
#(
  parameter int          DATA_W   = 8,
  parameter int unsigned PC_RESET = 0,
  parameter int unsigned SP_RESET = 'hFF00,
  localparam int         ADDR_W   = 2 * DATA_W
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              startValid,
  input  logic [OPC_W-1:0]  opcode,
  input  logic              flagZero,
  input  logic              flagCarry,
  input  logic              flagParity,
  input  logic              flagSign,
  input  logic [ADDR_W-1:0] hl,
  output logic              busy,
  output logic              done,
  output logic [CNT_W-1:0]  cycleCost,
  output logic [ADDR_W-1:0] pc,
  output logic [ADDR_W-1:0] sp,
  output logic              memReq,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  input  logic [DATA_W-1:0] memRdata
);

  seqStrobe_t strobe;

  branch_stack_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .startValid(startValid), .opcode(opcode),
    .flagZero(flagZero), .flagCarry(flagCarry), .flagParity(flagParity),
    .flagSign(flagSign), .strobe(strobe), .busy(busy), .done(done),
    .cycleCost(cycleCost)
  );

  branch_stack_dp #(.DATA_W(DATA_W), .PC_RESET(PC_RESET), .SP_RESET(SP_RESET)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .vecSel(opcode[5:3]), .hl(hl),
    .memRdata(memRdata), .pc(pc), .sp(sp), .memReq(memReq), .memWe(memWe),
    .memAddr(memAddr), .memWdata(memWdata)
  );

endmodule

// File: rtl/branch_stack_seq_chk.sv
module branch_stack_seq_chk #(
  parameter int DATA_W = 8,
  localparam int ADDR_W = 2 * DATA_W
)(
  input logic              clk,
  input logic              rstN,
  input logic              busy,
  input logic              done,
  input logic [4:0]        cycleCost,
  input logic [ADDR_W-1:0] pc,
  input logic [ADDR_W-1:0] sp,
  input logic              memReq,
  input logic              memWe,
  input logic [ADDR_W-1:0] memAddr
);

  // R10
  req_only_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> busy);

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busy |=> ($stable(pc) && $stable(sp)));

  // R4
  push_addr_chk: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> (memAddr == ADDR_W'(sp - 1'b1)));

  // R4
  push_dec_chk: assert property (@(posedge clk) disable iff (!rstN)
    memWe |=> (sp == ADDR_W'($past(sp) - 1'b1)));

  // R8
  done_ends_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !busy);

  // R8
  no_early_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> !done);

  // R8
  cost_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (cycleCost >= 5'd6 && cycleCost <= 5'd18));

endmodule

bind branch_stack_seq branch_stack_seq_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/branch_stack_seq_tb.sv
module branch_stack_seq_tb;

  typedef struct {
    logic [15:0] pc;
    logic [15:0] sp;
    int          cost;
    int          nAcc;
    string       tag;
  } doneItem_t;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startValid = 1'b0;
  logic [7:0]  opcode = 8'h00;
  logic        flagZero = 1'b0, flagCarry = 1'b0, flagParity = 1'b0, flagSign = 1'b0;
  logic [15:0] hl = 16'h0000;
  logic        busy, done, memReq, memWe;
  logic [4:0]  cycleCost;
  logic [15:0] pc, sp, memAddr;
  logic [7:0]  memWdata, memRdata;

  logic [7:0]  mem [0:255];
  logic [15:0] mPc, mSp;

  doneItem_t   expDone[$];
  logic [23:0] expWr[$];
  string       expWrTag[$];

  int nChecks = 0, nFails = 0, opsDone = 0;
  int busyCnt = 0, accCnt = 0;
  bit pending = 0;
  doneItem_t curItem;

  always #10 clk = ~clk;

  branch_stack_seq u_dut (
    .clk(clk), .rstN(rstN), .startValid(startValid), .opcode(opcode),
    .flagZero(flagZero), .flagCarry(flagCarry), .flagParity(flagParity),
    .flagSign(flagSign), .hl(hl), .busy(busy), .done(done), .cycleCost(cycleCost),
    .pc(pc), .sp(sp), .memReq(memReq), .memWe(memWe), .memAddr(memAddr),
    .memWdata(memWdata), .memRdata(memRdata)
  );

  assign memRdata = mem[memAddr[7:0]];
  always @(posedge clk) if (memReq && memWe) mem[memAddr[7:0]] <= memWdata;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  endtask

  // Monitor: compares writes and completions against the scoreboard
  always @(negedge clk) begin
    if (rstN) begin
      if (pending) begin
        check(pc == curItem.pc, curItem.tag, "final pc", pc, curItem.pc);
        check(sp == curItem.sp, curItem.tag, "final sp", sp, curItem.sp);
        pending = 0;
        opsDone++;
      end
      if (busy) begin
        busyCnt++;
        if (memReq) accCnt++;
      end
      if (memReq && memWe) begin
        if (expWr.size() == 0) begin
          check(0, "R10", "unexpected write", {memAddr, memWdata}, 0);
        end else begin
          logic [23:0] w;
          string t;
          w = expWr.pop_front();
          t = expWrTag.pop_front();
          check({memAddr, memWdata} == w, t, "push addr/data", {memAddr, memWdata}, w);
        end
      end
      if (done) begin
        if (expDone.size() == 0) begin
          check(0, "R9", "unexpected completion", pc, 0);
        end else begin
          curItem = expDone.pop_front();
          // R8 cost reported and busy length
          check(cycleCost == curItem.cost, "R8", "cycleCost", cycleCost, curItem.cost);
          check(busyCnt == curItem.nAcc * 0 + curItem.cost, "R8", "busy cycles",
                busyCnt, curItem.cost);
          // R10 number of memory accesses
          check(accCnt == curItem.nAcc, "R10", "access count", accCnt, curItem.nAcc);
          pending = 1;
        end
        busyCnt = 0;
        accCnt = 0;
      end
    end
  end

  function automatic bit ccTrue(input logic [2:0] cc, input logic [3:0] f);
    // f[0]=zero f[1]=carry f[2]=parity f[3]=sign
    case (cc)
      3'd0: return !f[0];
      3'd1: return  f[0];
      3'd2: return !f[1];
      3'd3: return  f[1];
      3'd4: return !f[2];
      3'd5: return  f[2];
      3'd6: return !f[3];
      default: return f[3];
    endcase
  endfunction

  task automatic putWord(input logic [15:0] a, input logic [15:0] w);
    logic [15:0] a1;
    a1 = a + 16'd1;
    mem[a[7:0]]  = w[7:0];
    mem[a1[7:0]] = w[15:8];
  endtask

  task automatic expPush(input logic [15:0] val, input string tag);
    logic [15:0] s1, s2;
    s1 = mSp - 16'd1;
    s2 = mSp - 16'd2;
    expWr.push_back({s1, val[15:8]}); expWrTag.push_back(tag);
    expWr.push_back({s2, val[7:0]});  expWrTag.push_back(tag);
    mSp = s2;
  endtask

  task automatic runOp(input logic [7:0] op, input logic [3:0] f,
                       input logic [15:0] hlv, input bit holdStart, input string tag);
    doneItem_t it;
    logic [15:0] a1, tgt, s1;
    bit taken;
    int target;
    a1 = mPc + 16'd1;
    tgt = {mem[a1[7:0]], mem[mPc[7:0]]};
    taken = ccTrue(op[5:3], f);
    it.tag = tag;
    if (op == 8'hC3 || (op[7:6] == 2'b11 && op[2:0] == 3'b010)) begin
      if (op == 8'hC3) taken = 1;
      it.cost = taken ? 10 : 7; it.nAcc = 2;
      mPc = taken ? tgt : mPc + 16'd2;
    end else if (op == 8'hCD || (op[7:6] == 2'b11 && op[2:0] == 3'b100)) begin
      if (op == 8'hCD) taken = 1;
      if (taken) begin
        expPush(mPc + 16'd2, tag);
        mPc = tgt;
      end else begin
        mPc = mPc + 16'd2;
      end
      it.cost = taken ? 18 : 9; it.nAcc = taken ? 4 : 2;
    end else if (op == 8'hC9 || (op[7:6] == 2'b11 && op[2:0] == 3'b000)) begin
      if (op == 8'hC9) begin
        taken = 1; it.cost = 10;
      end else begin
        it.cost = taken ? 12 : 6;
      end
      it.nAcc = taken ? 2 : 0;
      if (taken) begin
        s1 = mSp + 16'd1;
        mPc = {mem[s1[7:0]], mem[mSp[7:0]]};
        mSp = mSp + 16'd2;
      end
    end else if (op[7:6] == 2'b11 && op[2:0] == 3'b111) begin
      expPush(mPc, tag);
      mPc = {10'd0, op[5:3], 3'b000};
      it.cost = 12; it.nAcc = 2;
    end else begin
      mPc = hlv;
      it.cost = 6; it.nAcc = 0;
    end
    it.pc = mPc;
    it.sp = mSp;
    expDone.push_back(it);
    target = opsDone + 1;
    startValid = 1'b1; opcode = op; hl = hlv;
    {flagSign, flagParity, flagCarry, flagZero} = f;
    @(negedge clk);
    if (holdStart) begin
      opcode = 8'hE9; hl = 16'hDEAD; flagZero = ~flagZero;
    end else begin
      startValid = 1'b0;
    end
    wait (opsDone == target);
    startValid = 1'b0;
    // R10 every expected push seen
    check(expWr.size() == 0, "R10", "pending pushes", expWr.size(), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    check(0, "R8", "watchdog expired", 0, 1);
    finishRun();
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'(i * 7 + 3);
    mPc = 16'h0000;
    mSp = 16'hFF00;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(pc == 16'h0000, "R1", "reset pc", pc, 0);
    check(sp == 16'hFF00, "R1", "reset sp", sp, 16'hFF00);
    check(!busy && !done && !memReq, "R1", "reset busy/done/req",
          {busy, done, memReq}, 0);
    rstN = 1'b1;
    @(negedge clk);

    // R3 unconditional jump
    putWord(mPc, 16'h1230);
    runOp(8'hC3, 4'h0, 16'h0, 0, "R3");

    // R2 every condition code against every flag pattern
    for (int cc = 0; cc < 8; cc++) begin
      for (int f = 0; f < 16; f++) begin
        putWord(mPc, {8'(8'h20 + cc), 8'(8'h10 + f * 4)});
        runOp({2'b11, 3'(cc), 3'b010}, 4'(f), 16'h0, 0, "R2");
      end
    end

    // R4 unconditional and conditional calls
    putWord(mPc, 16'h3340);
    runOp(8'hCD, 4'h0, 16'h0, 0, "R4");
    for (int cc = 0; cc < 8; cc++) begin
      putWord(mPc, {8'(8'h40 + cc), 8'h50});
      runOp({2'b11, 3'(cc), 3'b100}, 4'h0, 16'h0, 0, "R4");
      putWord(mPc, {8'(8'h48 + cc), 8'h5F});
      runOp({2'b11, 3'(cc), 3'b100}, 4'hF, 16'h0, 0, "R4");
    end

    // R5 unconditional and conditional returns
    runOp(8'hC9, 4'h0, 16'h0, 0, "R5");
    for (int cc = 0; cc < 8; cc++) begin
      runOp({2'b11, 3'(cc), 3'b000}, 4'h0, 16'h0, 0, "R5");
      runOp({2'b11, 3'(cc), 3'b000}, 4'hF, 16'h0, 0, "R5");
    end

    // R6 restart to each vector
    for (int n = 0; n < 8; n++) begin
      runOp({2'b11, 3'(n), 3'b111}, 4'h0, 16'h0, 0, "R6");
    end

    // R7 load pc from hl
    runOp(8'hE9, 4'h0, 16'h5A6B, 0, "R7");

    // R9 start held through a whole jump, including its done cycle
    putWord(mPc, 16'h0744);
    runOp(8'hC3, 4'h0, 16'h0, 1, "R9");
    @(negedge clk);
    check(!busy, "R9", "held start not accepted", busy, 0);
    check(pc == mPc, "R9", "pc after held start", pc, mPc);

    // R9 unknown opcode ignored
    startValid = 1'b1; opcode = 8'h00;
    @(negedge clk);
    startValid = 1'b0;
    @(negedge clk);
    check(!busy, "R9", "unknown opcode busy", busy, 0);
    check(pc == mPc && sp == mSp, "R9", "unknown opcode pc", pc, mPc);

    finishRun();
  end

endmodule